// File: doc/BRIEF.md
# Eight-Lane Masked Writeback with Broadcast

This block sits at both ends of a packed 512-bit operation that works on eight 64-bit lanes. At the front it chooses the operand for each lane: either the lane's own slice of the source, or lane 0 of the source copied into every lane. The copy happens only when a broadcast request arrives together with a flag saying that the source came from memory. The per-lane arithmetic is outside this block. A results bus stands in for it, together with per-lane invalid and divide-by-zero exception bits.

At the back end the block registers the destination. Each active lane takes its computed result. An inactive lane either keeps its previous destination contents or is cleared to zero, depending on the masking mode. A lane is active when its mask bit is set or when masking is turned off. The exception bits of active lanes are ORed into two sticky flags, which stay set until a clear pulse arrives.

An operation whose reserved 4-bit register-specifier field is not all ones is rejected. A rejected operation raises an undefined-operation indication and leaves the destination and the flags untouched.

Top module: `lane_mask_wb`

## Requirements
- R1: Lane j occupies bits [64j+63:64j] of every 512-bit bus. Unless broadcast applies, operand lane j equals source lane j. Broadcast needs `bcast_i` and `src_mem_i` both at 1, so either bit alone leaves the lanes unchanged.
- R2: When `bcast_i` and `src_mem_i` are both 1, every operand lane equals source bits [63:0] (combinational path).
- R3: On an accepted strobe, lane j is active when `mask_en_i` is 0, or when `mask_en_i` is 1 and `mask_i[j]` is 1. An active lane of `dst_o` takes lane j of `res_i` at the clock edge where the strobe is sampled.
- R4: On an accepted strobe with `zeroing_i` at 0, every inactive lane of `dst_o` keeps its prior value.
- R5: On an accepted strobe with `zeroing_i` at 1, every inactive lane of `dst_o` becomes 64'h0.
- R6: A strobe is accepted only when `rsvd_spec_i` equals 4'b1111. Otherwise `undef_o` is 1 in the cycle after the edge, and `dst_o` and both flags (clear aside) keep their values.
- R7: On an accepted strobe, `flag_inv_o` and `flag_dz_o` gain the OR of `exc_inv_i` and `exc_dz_i` over active lanes only. Once set, a flag stays set until a clear.
- R8: `clr_flags_i` zeroes both flags at the edge where it is sampled. When it coincides with an accepted strobe, the flags then hold only that strobe's contributions.
- R9: Without a strobe, `dst_o` and the flags hold (clear aside) and `undef_o` is 0.
- R10: Synchronous active-high reset sets `dst_o`, both flags and `undef_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| rsvd_spec_i | input | 4 | Reserved register-specifier field; must be 4'b1111 |
| src_i | input | 512 | Source lanes |
| bcast_i | input | 1 | Broadcast request |
| src_mem_i | input | 1 | Source came from memory |
| opnd_o | output | 512 | Selected operand lanes for the arithmetic |
| res_i | input | 512 | Per-lane computed results |
| exc_inv_i | input | 8 | Per-lane invalid exception |
| exc_dz_i | input | 8 | Per-lane divide-by-zero exception |
| mask_en_i | input | 1 | Write mask in use |
| mask_i | input | 8 | Per-lane write mask |
| zeroing_i | input | 1 | 1 = zeroing, 0 = merging |
| clr_flags_i | input | 1 | Clear sticky flags |
| dst_o | output | 512 | Registered destination |
| flag_inv_o | output | 1 | Sticky invalid flag |
| flag_dz_o | output | 1 | Sticky divide-by-zero flag |
| undef_o | output | 1 | Operation rejected in the previous cycle |

## Verification
The bench sweeps all 256 masks under both masking modes, with the mask both in use and disabled, and walks through all four broadcast/memory combinations. A design that broadcast on either bit alone would corrupt lanes 1 to 7. A design that swapped merging and zeroing, or ignored a disabled mask, would produce wrong destination lanes. Exception bits are loaded on inactive lanes so that a flag accumulator that did not qualify by the mask would set a flag spuriously. All fifteen bad values of the reserved field are applied, and each must leave the destination and flags intact. Clears that coincide with a strobe expose the wrong priority between clearing and accumulating.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  localparam logic [3:0] SPEC_OK = 4'b1111;

  typedef struct packed {
    logic inv;
    logic dz;
  } exc_t;
endpackage

// File: rtl/lmw_opsel.sv
module lmw_opsel #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input  logic [LANES*LW-1:0] src_i,
  input  logic                bcast_i,
  input  logic                src_mem_i,
  output logic [LANES*LW-1:0] opnd_o
);
  logic use_lane0;
  assign use_lane0 = bcast_i & src_mem_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign opnd_o[j*LW +: LW] = use_lane0 ? src_i[LW-1:0] : src_i[j*LW +: LW];
  end
endmodule

// File: rtl/lmw_merge.sv
module lmw_merge #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [LANES-1:0]    act_i,
  input  logic                zeroing_i,
  input  logic [LANES*LW-1:0] res_i,
  output logic [LANES*LW-1:0] dst_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        dst_o[j*LW +: LW] <= '0;
      end else if (we_i) begin
        if (act_i[j])       dst_o[j*LW +: LW] <= res_i[j*LW +: LW];
        else if (zeroing_i) dst_o[j*LW +: LW] <= '0;
      end
    end
  end
endmodule

// File: rtl/lmw_flags.sv
module lmw_flags #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_i,
  input  logic             clr_i,
  input  logic [LANES-1:0] act_i,
  input  logic [LANES-1:0] inv_i,
  input  logic [LANES-1:0] dz_i,
  output lmw_pkg::exc_t    flags_o
);
  lmw_pkg::exc_t hit, base;

  always_comb begin
    hit.inv = acc_i & |(inv_i & act_i);
    hit.dz  = acc_i & |(dz_i & act_i);
    base    = clr_i ? '0 : flags_o;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= base | hit;
  end
endmodule

// File: rtl/lane_mask_wb.sv
module lane_mask_wb #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [3:0]          rsvd_spec_i,
  input  logic [LANES*LW-1:0] src_i,
  input  logic                bcast_i,
  input  logic                src_mem_i,
  output logic [LANES*LW-1:0] opnd_o,
  input  logic [LANES*LW-1:0] res_i,
  input  logic [LANES-1:0]    exc_inv_i,
  input  logic [LANES-1:0]    exc_dz_i,
  input  logic                mask_en_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic                zeroing_i,
  input  logic                clr_flags_i,
  output logic [LANES*LW-1:0] dst_o,
  output logic                flag_inv_o,
  output logic                flag_dz_o,
  output logic                undef_o
);
  logic             accept, reject;
  logic [LANES-1:0] act;
  lmw_pkg::exc_t    flags;

  assign accept = valid_i & (rsvd_spec_i == lmw_pkg::SPEC_OK);
  assign reject = valid_i & (rsvd_spec_i != lmw_pkg::SPEC_OK);
  assign act    = mask_en_i ? mask_i : {LANES{1'b1}};

  lmw_opsel #(.LANES(LANES), .LW(LW)) u_opsel (
    .src_i(src_i), .bcast_i(bcast_i), .src_mem_i(src_mem_i), .opnd_o(opnd_o)
  );

  lmw_merge #(.LANES(LANES), .LW(LW)) u_merge (
    .clk(clk), .rst(rst), .we_i(accept), .act_i(act),
    .zeroing_i(zeroing_i), .res_i(res_i), .dst_o(dst_o)
  );

  lmw_flags #(.LANES(LANES)) u_flags (
    .clk(clk), .rst(rst), .acc_i(accept), .clr_i(clr_flags_i),
    .act_i(act), .inv_i(exc_inv_i), .dz_i(exc_dz_i), .flags_o(flags)
  );

  assign flag_inv_o = flags.inv;
  assign flag_dz_o  = flags.dz;

  always_ff @(posedge clk) begin
    if (rst) undef_o <= 1'b0;
    else     undef_o <= reject;
  end
endmodule

// File: rtl/lmw_chk.sv
module lmw_chk #(
  parameter int LANES = 8,
  parameter int LW    = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                valid_i,
  input logic [3:0]          rsvd_spec_i,
  input logic [LANES*LW-1:0] src_i,
  input logic                bcast_i,
  input logic                src_mem_i,
  input logic [LANES*LW-1:0] opnd_o,
  input logic [LANES*LW-1:0] res_i,
  input logic                mask_en_i,
  input logic [LANES-1:0]    mask_i,
  input logic                zeroing_i,
  input logic                clr_flags_i,
  input logic [LANES*LW-1:0] dst_o,
  input logic                flag_inv_o,
  input logic                flag_dz_o,
  input logic                undef_o
);
  logic ok;
  assign ok = valid_i && rsvd_spec_i == 4'hF;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    p_bcast_r2: assert property (@(posedge clk) disable iff (rst)
      (bcast_i && src_mem_i) |-> opnd_o[j*LW +: LW] == src_i[LW-1:0]);
    p_own_lane_r1: assert property (@(posedge clk) disable iff (rst)
      !(bcast_i && src_mem_i) |-> opnd_o[j*LW +: LW] == src_i[j*LW +: LW]);
    p_write_r3: assert property (@(posedge clk) disable iff (rst)
      (ok && (!mask_en_i || mask_i[j])) |=> dst_o[j*LW +: LW] == $past(res_i[j*LW +: LW]));
    p_merge_r4: assert property (@(posedge clk) disable iff (rst)
      (ok && mask_en_i && !mask_i[j] && !zeroing_i) |=> $stable(dst_o[j*LW +: LW]));
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (ok && mask_en_i && !mask_i[j] && zeroing_i) |=> dst_o[j*LW +: LW] == '0);
  end

  p_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && rsvd_spec_i != 4'hF) |=> (undef_o && $stable(dst_o)));
  p_sticky_inv_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_inv_o && !clr_flags_i) |=> flag_inv_o);
  p_sticky_dz_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_dz_o && !clr_flags_i) |=> flag_dz_o);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_flags_i && !valid_i) |=> (!flag_inv_o && !flag_dz_o));
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(dst_o) && !undef_o));
endmodule

bind lane_mask_wb lmw_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .rsvd_spec_i(rsvd_spec_i),
  .src_i(src_i), .bcast_i(bcast_i), .src_mem_i(src_mem_i), .opnd_o(opnd_o),
  .res_i(res_i), .mask_en_i(mask_en_i), .mask_i(mask_i), .zeroing_i(zeroing_i),
  .clr_flags_i(clr_flags_i), .dst_o(dst_o), .flag_inv_o(flag_inv_o),
  .flag_dz_o(flag_dz_o), .undef_o(undef_o)
);

// File: tb/sim_lane_mask_wb.sv
module sim_lane_mask_wb;
  localparam int  LANES      = 8;
  localparam int  LW         = 64;
  localparam int  W          = LANES * LW;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic valid_i = 0, bcast_i = 0, src_mem_i = 0, mask_en_i = 0, zeroing_i = 0, clr_flags_i = 0;
  logic [3:0] rsvd_spec_i = 4'hF;
  logic [W-1:0] src_i = '0, res_i = '0, opnd_o, dst_o;
  logic [LANES-1:0] exc_inv_i = '0, exc_dz_i = '0, mask_i = '0;
  logic flag_inv_o, flag_dz_o, undef_o;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] e_dst = '0;
  logic e_inv = 0, e_dz = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_mask_wb #(.LANES(LANES), .LW(LW)) u0 (.*);

  task automatic chk(input string tag, input logic [LW-1:0] got, input logic [LW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_bus();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // model update, then one edge, then compare all outputs
  task automatic step();
    logic [LANES-1:0] act;
    logic acc;
    acc = valid_i && rsvd_spec_i == 4'hF;
    act = mask_en_i ? mask_i : '1;
    if (clr_flags_i) begin e_inv = 0; e_dz = 0; end
    if (acc) begin
      e_inv |= |(exc_inv_i & act);
      e_dz  |= |(exc_dz_i & act);
      for (int j = 0; j < LANES; j++)
        if (act[j]) e_dst[j*LW +: LW] = res_i[j*LW +: LW];
        else if (zeroing_i) e_dst[j*LW +: LW] = '0;
    end
    @(posedge clk); #1;
    for (int j = 0; j < LANES; j++)
      chk(!acc ? "R9/R6 dst" : (act[j] ? "R3 dst" : (zeroing_i ? "R5 dst" : "R4 dst")),
          dst_o[j*LW +: LW], e_dst[j*LW +: LW]);
    chk(clr_flags_i ? "R8 inv" : "R7 inv", LW'(flag_inv_o), LW'(e_inv));
    chk(clr_flags_i ? "R8 dz" : "R7 dz", LW'(flag_dz_o), LW'(e_dz));
    chk(valid_i && rsvd_spec_i != 4'hF ? "R6 undef" : "R9 undef",
        LW'(undef_o), LW'(valid_i && rsvd_spec_i != 4'hF));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R10 dst lane0", dst_o[LW-1:0], '0);
    chk("R10 dst lane7", dst_o[W-1 -: LW], '0);
    chk("R10 flags", LW'({flag_inv_o, flag_dz_o}), '0);
    chk("R10 undef", LW'(undef_o), '0);

    for (int me = 0; me < 2; me++)
      for (int z = 0; z < 2; z++)
        for (int m = 0; m < 256; m++) begin
          src_i = rnd_bus(); res_i = rnd_bus();
          mask_en_i = me[0]; zeroing_i = z[0]; mask_i = m[7:0];
          bcast_i = m[0]; src_mem_i = m[1];
          // exceptions mostly on masked-off lanes to expose unqualified OR
          exc_inv_i = (m % 5 == 0) ? 8'h01 << (m % 8) : ~mask_i & 8'h5A;
          exc_dz_i  = (m % 7 == 0) ? mask_i : ~mask_i & 8'hA5;
          clr_flags_i = (m % 3 == 0);
          rsvd_spec_i = 4'hF; valid_i = 1;
          #1;
          for (int j = 0; j < LANES; j++)
            chk(bcast_i && src_mem_i ? "R2 opnd" : "R1 opnd", opnd_o[j*LW +: LW],
                (bcast_i && src_mem_i) ? src_i[LW-1:0] : src_i[j*LW +: LW]);
          step();
        end

    // rejected operations: every bad reserved value
    for (int s = 0; s < 15; s++) begin
      rsvd_spec_i = s[3:0]; valid_i = 1; mask_en_i = 0;
      res_i = rnd_bus(); exc_inv_i = '1; exc_dz_i = '1; clr_flags_i = 0;
      step();
    end

    // idle cycles with changing inputs
    rsvd_spec_i = 4'hF; valid_i = 0;
    for (int s = 0; s < 4; s++) begin
      res_i = rnd_bus(); exc_inv_i = '1; exc_dz_i = '1; clr_flags_i = 0;
      step();
    end
    // set flags, then a lone clear
    valid_i = 1; mask_en_i = 0; step();
    valid_i = 0; clr_flags_i = 1; step();
    clr_flags_i = 0; step();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule